// File: doc/BRIEF.md
# Memory Region Access Filter

This block sits in front of a memory controller and rules on every transaction: permit or deny. Software sets it up through a register file of `2*NUM_RGN+1` 32-bit control words. With the defaults there are 17 words. The bus side presents an address, a non-secure flag and a valid strobe. One clock later the block returns a registered verdict.

There are eight programmable windows. Each window has a first and a last megabyte, and both bounds are inclusive. A per-window enable bitmap turns protection on for each window. A catch-all enable protects every address that no window covers. A global bypass switch permits everything. Secure transactions are always let through. A non-secure transaction is refused only when all of the following hold:

- bypass is clear;
- the address lies in an enabled window, or it lies in no window while the catch-all enable is set.

Top module: `mem_region_firewall`

## Requirements
- R1: The megabyte index is `acc_addr[ADDR_W-1:20]`, and address bits [19:0] have no effect on the verdict. Word n (n < 8) holds the first megabyte of window n. Word n+8 holds its last megabyte. A window covers every megabyte m with first <= m <= last.
- R2: A window whose first and last bounds are both 0 covers exactly megabyte 0, which is addresses 0x0 to 0xFFFFF.
- R3: A window whose last bound is below its first bound covers no address.
- R4: Word 16, bit i, enables protection for window i. A window with its bit at 0 never causes a refusal.
- R5: Word 16, bit 8, is the catch-all enable. When it is 1, a non-secure access that falls in no window is refused, whether or not the window bits are enabled. An access inside a disabled window only is permitted.
- R6: Word 16, bit 9, is the bypass. When it is 1, every access is permitted.
- R7: An access with `acc_nonsec` = 0 is always permitted.
- R8: Enabled windows that overlap combine as a logical OR.
- R9: A write updates data bit i (i < 16) only when write-data bit i+16 is 1. Reads return 0 in bits [31:16]. Word 16 reads 0 in bits [15:10]. A write or read at an index above 16 has no effect and reads 0.
- R10: After reset, all bound words read 0 and word 16 reads 0x200, which means bypass is on.
- R11: `resp_valid` is high exactly one cycle after `acc_valid`. `resp_permit` is 0 whenever `resp_valid` is 0. The verdict uses the configuration held at the time of the access cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_widx | input | IDX_W | Index of the word to write |
| cfg_wdata | input | 32 | Write data: mask in [31:16], value in [15:0] |
| cfg_ridx | input | IDX_W | Index of the word to read |
| cfg_rdata | output | 32 | Read data, combinational |
| acc_valid | input | 1 | Transaction present |
| acc_addr | input | ADDR_W | Transaction byte address |
| acc_nonsec | input | 1 | 1 for a non-secure transaction |
| resp_valid | output | 1 | Verdict valid, one cycle after acc_valid |
| resp_permit | output | 1 | 1 to permit, 0 to refuse |

## Verification
The hardest situation to reach is one where several rules meet at a single address. Examples are a megabyte covered by both a disabled and an enabled window, an empty window next to covered megabytes, and megabyte 0 covered at once by a zero-bounded enabled window and by disabled windows that reset left at 0/0.

The bench builds a 24-bit address configuration, which gives 16 megabytes. It programs one layout that contains all of these cases at the same time. It then sweeps every megabyte at its lowest and highest byte offset, with both security flags, under four settings of the enable word. Each verdict is compared with a model computed in the bench.

// File: rtl/mfw_pkg.sv
// Package: shared constants and the masked half-word merge.
// Assumes control words carry a 16-bit mask in [31:16] over data in [15:0].
package mfw_pkg;
    localparam int HALF_W = 16;
    localparam int WORD_W = 32;

    // Merge new data into an old half-word, only where the mask bit is set.
    function automatic logic [HALF_W-1:0] merge_half(
        input logic [HALF_W-1:0] old_v,
        input logic [WORD_W-1:0] wr_v
    );
        return (old_v & ~wr_v[WORD_W-1:HALF_W]) | (wr_v[HALF_W-1:0] & wr_v[WORD_W-1:HALF_W]);
    endfunction
endpackage

// File: rtl/mfw_regfile.sv
// Module: control register file holding window bounds, enable bitmap,
// catch-all and bypass bits. Every write is masked per bit.
// Assumes NUM_RGN+2 <= 16 so the enable word fits in the low half.
module mfw_regfile
    import mfw_pkg::*;
#(
    parameter int NUM_RGN = 8,
    localparam int NWORDS = 2*NUM_RGN + 1,
    localparam int IDX_W  = $clog2(NWORDS),
    localparam int CTL_W  = NUM_RGN + 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [IDX_W-1:0]               widx,
    input  logic [WORD_W-1:0]              wdata,
    input  logic [IDX_W-1:0]               ridx,
    output logic [WORD_W-1:0]              rdata,
    output logic [NUM_RGN-1:0][HALF_W-1:0] first_o,
    output logic [NUM_RGN-1:0][HALF_W-1:0] last_o,
    output logic [NUM_RGN-1:0]             en_o,
    output logic                           catch_o,
    output logic                           bypass_o
);
    localparam int CTL_IDX = 2*NUM_RGN;

    logic [CTL_W-1:0] ctl_q;

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_bounds
        logic [HALF_W-1:0] first_q, last_q;
        // Hold the first and last megabyte of window g.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                first_q <= '0;
                last_q  <= '0;
            end else if (we) begin
                if (widx == IDX_W'(g))           first_q <= merge_half(first_q, wdata);
                if (widx == IDX_W'(g + NUM_RGN)) last_q  <= merge_half(last_q, wdata);
            end
        end
        assign first_o[g] = first_q;
        assign last_o[g]  = last_q;
    end

    // Hold the enable bitmap, catch-all and bypass; bypass is set at reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= CTL_W'(1) << (CTL_W - 1);
        else if (we && widx == IDX_W'(CTL_IDX))
            ctl_q <= CTL_W'(merge_half(HALF_W'(ctl_q), wdata));
    end

    assign en_o     = ctl_q[NUM_RGN-1:0];
    assign catch_o  = ctl_q[NUM_RGN];
    assign bypass_o = ctl_q[NUM_RGN+1];

    // Read multiplexer; unknown indices and the upper half return zero.
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_RGN; i++) begin
            if (ridx == IDX_W'(i))           rdata[HALF_W-1:0] = first_o[i];
            if (ridx == IDX_W'(i + NUM_RGN)) rdata[HALF_W-1:0] = last_o[i];
        end
        if (ridx == IDX_W'(CTL_IDX)) rdata[CTL_W-1:0] = ctl_q;
    end

    // R9: a write with an all-zero mask changes no stored bit.
    p_zero_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wdata[WORD_W-1:HALF_W] == '0) |=>
        ($stable(first_o) && $stable(last_o) && $stable(ctl_q)));
endmodule

// File: rtl/mfw_match.sv
// Module: compares a megabyte index against every window's inclusive
// [first, last] range. Assumes the index is no wider than 16 bits.
module mfw_match
    import mfw_pkg::*;
#(
    parameter int NUM_RGN = 8,
    parameter int MB_W    = 12
) (
    input  logic [MB_W-1:0]                mb,
    input  logic [NUM_RGN-1:0][HALF_W-1:0] first_i,
    input  logic [NUM_RGN-1:0][HALF_W-1:0] last_i,
    output logic [NUM_RGN-1:0]             hit
);
    logic [HALF_W-1:0] mb_ext;
    assign mb_ext = HALF_W'(mb);

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_cmp
        // Window g covers the index when first <= index <= last.
        assign hit[g] = (mb_ext >= first_i[g]) && (mb_ext <= last_i[g]);
    end
endmodule

// File: rtl/mem_region_firewall.sv
// Module: top of the memory region access filter. Looks up the access
// megabyte in all windows, forms the verdict and registers it.
// Assumes 21 <= ADDR_W <= 36 and the configuration is stable across the access.
module mem_region_firewall
    import mfw_pkg::*;
#(
    parameter int NUM_RGN = 8,
    parameter int ADDR_W  = 32,
    localparam int IDX_W  = $clog2(2*NUM_RGN + 1),
    localparam int MB_W   = ADDR_W - 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_widx,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic [IDX_W-1:0]  cfg_ridx,
    output logic [WORD_W-1:0] cfg_rdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_nonsec,
    output logic              resp_valid,
    output logic              resp_permit
);
    logic [NUM_RGN-1:0][HALF_W-1:0] first_w, last_w;
    logic [NUM_RGN-1:0]             en_w, hit_w;
    logic                           catch_w, bypass_w, refuse;

    mfw_regfile #(.NUM_RGN(NUM_RGN)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .widx     (cfg_widx),
        .wdata    (cfg_wdata),
        .ridx     (cfg_ridx),
        .rdata    (cfg_rdata),
        .first_o  (first_w),
        .last_o   (last_w),
        .en_o     (en_w),
        .catch_o  (catch_w),
        .bypass_o (bypass_w)
    );

    mfw_match #(.NUM_RGN(NUM_RGN), .MB_W(MB_W)) u_match (
        .mb      (acc_addr[ADDR_W-1:20]),
        .first_i (first_w),
        .last_i  (last_w),
        .hit     (hit_w)
    );

    // Refuse a non-secure access in an enabled window or in no window under catch-all.
    always_comb begin
        refuse = acc_nonsec && !bypass_w &&
                 ((|(hit_w & en_w)) || (!(|hit_w) && catch_w));
    end

    // Register the verdict; the permit is low whenever no response is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_permit <= 1'b0;
        end else begin
            resp_valid  <= acc_valid;
            resp_permit <= acc_valid && !refuse;
        end
    end

    // R11: every access gets a response on the next cycle.
    p_resp_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> resp_valid);
    // R11: no access, no response and no permit.
    p_resp_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!resp_valid && !resp_permit));
    // R7: secure accesses are never refused.
    p_secure_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_nonsec) |=> resp_permit);
    // R6: bypass permits every access.
    p_bypass_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && bypass_w) |=> resp_permit);
endmodule

// File: tb/mem_region_firewall_tb.sv
module mem_region_firewall_tb;
    localparam int NR = 8;
    localparam int AW = 24;
    localparam int IW = $clog2(2*NR + 1);
    localparam int NMB = 1 << (AW - 20);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [IW-1:0] cfg_widx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [IW-1:0] cfg_ridx = '0;
    logic [31:0] cfg_rdata;
    logic acc_valid = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic acc_nonsec = 1'b0;
    logic resp_valid, resp_permit;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    int m_first[NR];
    int m_last[NR];
    int m_ctl;

    always #2 clk = ~clk;

    mem_region_firewall #(.NUM_RGN(NR), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_widx(cfg_widx),
        .cfg_wdata(cfg_wdata), .cfg_ridx(cfg_ridx), .cfg_rdata(cfg_rdata),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_nonsec(acc_nonsec),
        .resp_valid(resp_valid), .resp_permit(resp_permit)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_widx = IW'(idx); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input int idx, input logic [31:0] exp, input string tag);
        cfg_ridx = IW'(idx);
        #1;
        check(tag, cfg_rdata, exp);
    endtask

    function automatic bit model_permit(input int mb, input bit ns);
        bit any_hit = 0;
        bit en_hit = 0;
        for (int i = 0; i < NR; i++) begin
            if (mb >= m_first[i] && mb <= m_last[i]) begin
                any_hit = 1;
                if (m_ctl[i]) en_hit = 1;
            end
        end
        if (!ns || m_ctl[9]) return 1;
        return !(en_hit || (!any_hit && m_ctl[8]));
    endfunction

    task automatic access(input logic [AW-1:0] a, input bit ns, input bit exp, input string tag);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_nonsec = ns;
        @(negedge clk);
        acc_valid = 1'b0;
        check("R11 resp_valid", 32'(resp_valid), 32'd1);
        check(tag, 32'(resp_permit), 32'(exp));
    endtask

    task automatic sweep(input string tag);
        for (int mb = 0; mb < NMB; mb++) begin
            for (int k = 0; k < 2; k++) begin
                for (int ns = 0; ns < 2; ns++) begin
                    logic [AW-1:0] a;
                    a = {4'(mb), (k == 1) ? 20'hFFFFF : 20'h00000};
                    access(a, ns[0], model_permit(mb, ns[0]), (ns == 0) ? "R7" : tag);
                end
            end
        end
    endtask

    task automatic set_ctl(input int v);
        m_ctl = v;
        wr(16, 32'hFFFF_0000 | 32'(v));
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NR; i++) begin m_first[i] = 0; m_last[i] = 0; end
        m_ctl = 32'h200;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset values; R11: no response while idle.
        for (int i = 0; i < 16; i++) rd_chk(i, 32'h0, "R10 bound reset");
        rd_chk(16, 32'h200, "R10 control reset");
        check("R11 idle valid", 32'(resp_valid), 32'd0);
        check("R11 idle permit", 32'(resp_permit), 32'd0);

        // Reset configuration: bypass on, all permitted (R6, R10).
        sweep("R10 bypass after reset");

        // Layout: overlap (R8), zero window (R2), empty window (R3), disabled (R4).
        begin
            int f[NR] = '{2, 3, 0, 9, 10, 0, 0, 0};
            int l[NR] = '{4, 3, 0, 7, 12, 0, 0, 0};
            for (int i = 0; i < NR; i++) begin
                m_first[i] = f[i]; m_last[i] = l[i];
                wr(i, 32'hFFFF_0000 | 32'(f[i]));
                wr(i + NR, 32'hFFFF_0000 | 32'(l[i]));
            end
        end
        rd_chk(3, 32'h9, "R1 first bound readback");
        rd_chk(12, 32'hC, "R1 last bound readback");

        set_ctl(32'h00F);
        sweep("R1 R2 R3 R4 R8 windows");
        set_ctl(32'h10F);
        sweep("R5 catch-all");
        // Write-then-access: configuration applies from the next cycle (R11).
        access({4'd13, 20'h12345}, 1'b1, 1'b0, "R5 R11 catch-all fresh config");
        set_ctl(32'h30F);
        sweep("R6 bypass");

        // R9: masked writes.
        wr(4, 32'h0000_FFFF);
        rd_chk(4, 32'h000A, "R9 zero mask ignored");
        wr(4, 32'h00F0_0F35);
        rd_chk(4, 32'h003A, "R9 partial mask");
        wr(16, 32'hFFFF_FFFF);
        rd_chk(16, 32'h3FF, "R9 control word width");
        wr(20, 32'hFFFF_1234);
        rd_chk(20, 32'h0, "R9 out of range index");
        rd_chk(16, 32'h3FF, "R9 out of range write no effect");
        access({4'd2, 20'h0}, 1'b1, 1'b1, "R6 bypass with all enables");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule